// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small microcontroller run. It has three operating conditions: full run, idle and deep sleep. In idle, only the CPU clock is stopped. In deep sleep, the oscillator is also stopped. Software selects a mode by writing a four-bit mode register. Bit 0 requests idle, bit 1 requests deep sleep, and bits 2 and 3 are two spare flags. Software can use the flags to record why it went to sleep.

The block leaves idle on any enabled interrupt request. It leaves deep sleep in one of two ways:

- An enabled external interrupt pin is held low. The oscillator restarts, and run resumes only after the pin goes high again and a stabilization count has finished.
- An enabled keyboard interrupt arrives. This starts a fixed wait before run resumes.

A reset pin is accepted only after it has been held high for a set number of consecutive cycles. An accepted reset returns the block to run and clears the whole mode register.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst`, the CPU, peripheral and oscillator enables are all 1, `mode_q` reads 0, and `rst_valid` and `wake` are 0.
- R2: A write in run with bit 0 set (bit 1 clear) enters idle. From the next cycle `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1, and `mode_q[0]` reads 1.
- R3: In idle, `irq_any`=1 returns to run on the next clock edge. `mode_q[0]` reads 0 again, and `wake` is 1 for exactly one cycle.
- R4: A write in run with bit 1 set enters deep sleep even if bit 0 is also set. All three enables become 0, `mode_q[1]`=1 and `mode_q[0]`=0.
- R5: In deep sleep, the following do not wake the block: `irq_any`, a low level on an external pin whose enable is 0, and a keyboard request with `kbd_en`=0. An enabled external pin (`ext_int_n[i]`=0 with `ext_int_en[i]`=1) sets `osc_en`=1 on the next edge, while the CPU and peripheral enables stay 0.
- R6: After a pin-triggered restart, run (all enables 1, `wake` pulsed) resumes only after both of these hold: the pin has gone high, and `STAB_CYC` cycles have passed with the oscillator on. If the pin is released early, the oscillator-on/CPU-off window lasts exactly `STAB_CYC` cycles. If the pin is held longer, run resumes one edge after the release.
- R7: When both external pins are low during a restart, releasing either one completes the exit, even if the other is still low.
- R8: A keyboard wake-up keeps the oscillator on with the CPU off for exactly `KBD_WAIT` cycles, then returns to run with `wake` pulsed.
- R9: Flag bits 2 and 3 of `mode_q` change only when software writes them in run. They are unchanged by entering or leaving idle or deep sleep.
- R10: `rst_pin` held high for `RST_HOLD` consecutive cycles raises `rst_valid`. On the next edge the block returns to run with `mode_q`=0. A shorter high pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | External reset pin, active high, filtered |
| mode_we | input | 1 | Mode register write strobe (taken only in run) |
| mode_wdata | input | 4 | Write data: bit0 idle, bit1 deep sleep, bits 2-3 flags |
| mode_q | output | 4 | Mode register read value |
| irq_any | input | 1 | Some enabled interrupt is pending |
| ext_int_n | input | 2 | External interrupt pins, active low |
| ext_int_en | input | 2 | Per-pin interrupt enable |
| kbd_irq | input | 1 | Keyboard interrupt request |
| kbd_en | input | 1 | Keyboard interrupt enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| osc_en | output | 1 | Oscillator enable |
| rst_valid | output | 1 | Reset pin accepted |
| wake | output | 1 | One-cycle pulse on return to run by interrupt |

## Verification
Deep sleep is exited with several distinct pin patterns, and each one separates a different mistake:

- A short low pulse that is released early shows that the stabilization count, not the pin, bounds the exit.
- A pin held well past the count shows that the release, not the count, bounds the exit.
- Two overlapping lows, where one is released while the other stays low, separate a first-release exit from one that waits for all pins.
- Wake sources that are disabled or do not apply (a masked pin, a masked keyboard request, a generic interrupt) must leave the oscillator off.
- A keyboard wake is timed to the exact cycle.
- Reset pulses one cycle shorter than the hold time and exactly at it show where the reset filter accepts the pin.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int MODE_W   = 4;
    localparam int IDLE_BIT = 0;
    localparam int PD_BIT   = 1;
    localparam int FLAG_LO  = 2;
    localparam int FLAG_HI  = 3;
    localparam int N_EXT    = 2;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_PD_SLEEP = 3'd2,
        ST_PD_OSC   = 3'd3,
        ST_PD_KBD   = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_en_t;

    function automatic clk_en_t enables_for(pm_state_e s);
        clk_en_t e;
        case (s)
            ST_RUN:      e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
            ST_IDLE:     e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            ST_PD_OSC,
            ST_PD_KBD:   e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            default:     e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
        endcase
        return e;
    endfunction

    function automatic logic in_deep_sleep(pm_state_e s);
        return (s == ST_PD_SLEEP) || (s == ST_PD_OSC) || (s == ST_PD_KBD);
    endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic valid
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    logic [CW-1:0] run_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len_q <= '0;
        end else if (!pin) begin
            run_len_q <= '0;
        end else if (run_len_q != HOLD_C) begin
            run_len_q <= run_len_q + 1'b1;
        end
    end

    assign valid = (run_len_q == HOLD_C);

    // R10: acceptance is only ever preceded by the pin being high
    p_accept_after_pin_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(pin));

endmodule

// File: rtl/pwr_delay_cnt.sv
module pwr_delay_cnt #(
    parameter int MAX = 1024
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic [$clog2(MAX+1)-1:0]   limit,
    output logic                       done
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == limit);

    // R6/R8: the count never runs past its limit
    p_count_bounded_r8: assert property (@(posedge clk) disable iff (rst || clr)
        done |=> done || $past(clr));

endmodule

// File: rtl/pwr_pin_wake.sv
module pwr_pin_wake #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         track,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] pin_en,
    output logic         any_low,
    output logic         released
);
    logic [N-1:0] low_now;
    logic [N-1:0] held_q;
    logic         rel_q;
    logic         rel_now;

    assign low_now = pin_en & ~pin_n;
    assign any_low = |low_now;
    assign rel_now = |(held_q & pin_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            rel_q  <= 1'b0;
        end else if (arm) begin
            held_q <= low_now;
            rel_q  <= 1'b0;
        end else if (track) begin
            held_q <= held_q | low_now;
            rel_q  <= rel_q | rel_now;
        end
    end

    assign released = rel_q | rel_now;

    // R7: once a held pin is seen released, the release is remembered while tracking
    p_release_sticky_r7: assert property (@(posedge clk) disable iff (rst || arm)
        (track && released) |=> (released || !track));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYC = 16,
    parameter int KBD_WAIT = 1024,
    parameter int RST_HOLD = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_pin,
    input  logic                 mode_we,
    input  logic [MODE_W-1:0]    mode_wdata,
    output logic [MODE_W-1:0]    mode_q,
    input  logic                 irq_any,
    input  logic [N_EXT-1:0]     ext_int_n,
    input  logic [N_EXT-1:0]     ext_int_en,
    input  logic                 kbd_irq,
    input  logic                 kbd_en,
    output logic                 cpu_clk_en,
    output logic                 per_clk_en,
    output logic                 osc_en,
    output logic                 rst_valid,
    output logic                 wake
);
    localparam int MAXC = (STAB_CYC > KBD_WAIT) ? STAB_CYC : KBD_WAIT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STAB_LIM = CW'(STAB_CYC - 1);
    localparam logic [CW-1:0] KBD_LIM  = CW'(KBD_WAIT - 1);

    pm_state_e   st_q, st_d;
    logic [1:0]  flags_q;
    logic        wake_q;
    logic        sreset;
    logic        cnt_done, cnt_clr;
    logic [CW-1:0] cnt_limit;
    logic        pin_low, pin_rel;
    logic        run_wr;
    clk_en_t     en;

    pwr_rst_filter #(.HOLD(RST_HOLD)) u_rst_filter (
        .clk   (clk),
        .rst   (rst),
        .pin   (rst_pin),
        .valid (rst_valid)
    );

    assign sreset = rst | rst_valid;

    assign cnt_clr   = !((st_q == ST_PD_OSC) || (st_q == ST_PD_KBD));
    assign cnt_limit = (st_q == ST_PD_KBD) ? KBD_LIM : STAB_LIM;

    pwr_delay_cnt #(.MAX(MAXC)) u_delay (
        .clk   (clk),
        .rst   (sreset),
        .clr   (cnt_clr),
        .limit (cnt_limit),
        .done  (cnt_done)
    );

    pwr_pin_wake #(.N(N_EXT)) u_pin_wake (
        .clk      (clk),
        .rst      (sreset),
        .arm      (st_q == ST_PD_SLEEP),
        .track    (st_q == ST_PD_OSC),
        .pin_n    (ext_int_n),
        .pin_en   (ext_int_en),
        .any_low  (pin_low),
        .released (pin_rel)
    );

    assign run_wr = (st_q == ST_RUN) && mode_we;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN: begin
                if (run_wr) begin
                    if (mode_wdata[PD_BIT])        st_d = ST_PD_SLEEP;
                    else if (mode_wdata[IDLE_BIT]) st_d = ST_IDLE;
                end
            end
            ST_IDLE:     if (irq_any) st_d = ST_RUN;
            ST_PD_SLEEP: begin
                if (pin_low)                st_d = ST_PD_OSC;
                else if (kbd_en && kbd_irq) st_d = ST_PD_KBD;
            end
            ST_PD_OSC:   if (cnt_done && pin_rel) st_d = ST_RUN;
            ST_PD_KBD:   if (cnt_done) st_d = ST_RUN;
            default:     st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sreset) begin
            st_q    <= ST_RUN;
            flags_q <= '0;
            wake_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            wake_q <= (st_d == ST_RUN) && (st_q != ST_RUN);
            if (run_wr) flags_q <= mode_wdata[FLAG_HI:FLAG_LO];
        end
    end

    assign en         = enables_for(st_q);
    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign osc_en     = en.osc;
    assign wake       = wake_q;
    assign mode_q     = {flags_q, in_deep_sleep(st_q), (st_q == ST_IDLE)};

    // R4: a deep-sleep write wins over a simultaneous idle request
    p_pd_priority_r4: assert property (@(posedge clk) disable iff (sreset)
        (run_wr && mode_wdata[PD_BIT]) |=> (!osc_en && !mode_q[IDLE_BIT]));

    // R3: an interrupt in idle returns to run with a wake pulse
    p_idle_exit_r3: assert property (@(posedge clk) disable iff (sreset)
        (st_q == ST_IDLE && irq_any) |=> (cpu_clk_en && wake));

    // R3: the wake indication lasts a single cycle
    p_wake_single_r3: assert property (@(posedge clk) disable iff (sreset)
        wake |=> !wake);

    // R9: flags move only on a software write in run
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (sreset)
        !run_wr |=> $stable(mode_q[FLAG_HI:FLAG_LO]));

    // R6: the CPU clock never returns before stabilization completes
    p_no_early_cpu_r6: assert property (@(posedge clk) disable iff (sreset)
        (st_q == ST_PD_OSC && !cnt_done) |=> !cpu_clk_en);

    // R5: with no enabled pin or keyboard source, deep sleep keeps the oscillator off
    p_sleep_holds_r5: assert property (@(posedge clk) disable iff (sreset)
        (st_q == ST_PD_SLEEP && !pin_low && !(kbd_en && kbd_irq)) |=> !osc_en);

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAB  = 16;
    localparam int KWAIT = 1024;
    localparam int RHOLD = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic [3:0] mode_q;
    logic       irq_any = 1'b0;
    logic [1:0] ext_int_n = 2'b11;
    logic [1:0] ext_int_en = 2'b00;
    logic       kbd_irq = 1'b0;
    logic       kbd_en = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en, rst_valid, wake;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq #(.STAB_CYC(STAB), .KBD_WAIT(KWAIT), .RST_HOLD(RHOLD)) u_dut (
        .clk(clk), .rst(rst), .rst_pin(rst_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
        .irq_any(irq_any), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
        .kbd_irq(kbd_irq), .kbd_en(kbd_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .rst_valid(rst_valid), .wake(wake)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mode(logic [3:0] v);
        mode_we = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0; mode_wdata = '0;
    endtask

    function automatic logic [2:0] ens();
        return {cpu_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic t_reset();
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        chk("R1", "enables", ens(), 3'b111);
        chk("R1", "mode_q", mode_q, 4'h0);
        chk("R1", "rst_valid/wake", {rst_valid, wake}, 2'b00);
    endtask

    task automatic t_idle();
        write_mode(4'b0101);
        chk("R2", "idle enables", ens(), 3'b011);
        chk("R2", "idle mode_q", mode_q, 4'b0101);
        step(3);
        chk("R2", "idle held", ens(), 3'b011);
        irq_any = 1'b1; step(1); irq_any = 1'b0;
        chk("R3", "run enables", ens(), 3'b111);
        chk("R3", "idle bit cleared", mode_q, 4'b0100);
        chk("R3", "wake pulse", wake, 1'b1);
        step(1);
        chk("R3", "wake ends", wake, 1'b0);
    endtask

    task automatic t_pd_early_release();
        int n = 0;
        write_mode(4'b1011);
        chk("R4", "pd enables", ens(), 3'b000);
        chk("R4", "pd priority mode_q", mode_q, 4'b1010);
        irq_any = 1'b1; ext_int_n = 2'b10; kbd_irq = 1'b1;
        step(3);
        irq_any = 1'b0; ext_int_n = 2'b11; kbd_irq = 1'b0;
        chk("R5", "ignored sources", ens(), 3'b000);
        ext_int_en = 2'b01; ext_int_n = 2'b10; step(1);
        chk("R5", "osc restart", ens(), 3'b001);
        while (osc_en && !cpu_clk_en && n < 5000) begin
            n++;
            if (n == 2) ext_int_n = 2'b11;
            @(negedge clk);
        end
        chk("R6", "stab window", n, STAB);
        chk("R6", "run after stab", ens(), 3'b111);
        chk("R6", "wake on exit", wake, 1'b1);
        chk("R9", "flags kept", mode_q, 4'b1000);
    endtask

    task automatic t_pd_long_hold();
        write_mode(4'b0010);
        ext_int_n = 2'b10; step(3 * STAB);
        chk("R6", "held pin blocks cpu", ens(), 3'b001);
        ext_int_n = 2'b11; step(1);
        chk("R6", "release completes", ens(), 3'b111);
        chk("R9", "flags cleared by write", mode_q, 4'b0000);
    endtask

    task automatic t_both_pins();
        ext_int_en = 2'b11;
        write_mode(4'b0010);
        ext_int_n = 2'b10; step(2);
        ext_int_n = 2'b00; step(STAB + 5);
        chk("R7", "both low held", ens(), 3'b001);
        ext_int_n = 2'b01; step(1);
        chk("R7", "first release exits", ens(), 3'b111);
        ext_int_n = 2'b11; ext_int_en = 2'b00; step(1);
    endtask

    task automatic t_kbd();
        int n = 0;
        kbd_en = 1'b1;
        write_mode(4'b0110);
        kbd_irq = 1'b1; step(1); kbd_irq = 1'b0;
        while (osc_en && !cpu_clk_en && n < 5000) begin
            n++;
            @(negedge clk);
        end
        chk("R8", "kbd wait", n, KWAIT);
        chk("R8", "kbd run+wake", {ens(), wake}, 4'b1111);
        chk("R9", "flag after kbd", mode_q, 4'b0100);
        kbd_en = 1'b0;
    endtask

    task automatic t_reset_pin();
        logic seen = 1'b0;
        write_mode(4'b1101);
        rst_pin = 1'b1;
        for (int i = 0; i < RHOLD - 1; i++) begin
            step(1);
            seen = seen | rst_valid;
        end
        rst_pin = 1'b0; step(1);
        chk("R10", "short pulse no accept", seen, 1'b0);
        chk("R10", "short pulse keeps state", mode_q, 4'b1101);
        rst_pin = 1'b1; step(RHOLD);
        chk("R10", "accepted", rst_valid, 1'b1);
        step(1);
        chk("R10", "reset state", {ens(), mode_q}, 7'b1110000);
        rst_pin = 1'b0; step(1);
        chk("R10", "release", rst_valid, 1'b0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_idle();
        t_pd_early_release();
        t_pd_long_hold();
        t_both_pins();
        t_kbd();
        t_reset_pin();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule